// File: doc/BRIEF.md
# Raw Bit Stream Whitener

The whitener takes a serial stream of raw random bits, each marked by a one-cycle valid strobe, and turns it into a cleaner stream at one quarter of the rate. Each group of four accepted raw bits is folded into one parity bit. That parity is then added modulo 2 to one bit of a maximal-length pseudo-random sequence, and the result leaves the block as a single whitened bit with its own valid pulse. The fold breaks up short-range correlation and bias. The sequence term flattens the distribution that remains.

Grouping is done by a small state machine with three named states. GRP_FIRST waits for the first bit of a group and loads the parity accumulator. On every accepted bit it moves to GRP_MID (group size above two) or to GRP_LAST (group size of two). GRP_MID adds the middle bits into the accumulator and moves on to GRP_LAST once all bits except the last are in. GRP_LAST takes the closing bit, fires the group-complete strobe, clears the accumulator and returns to GRP_FIRST. A cycle with the valid strobe low leaves every state unchanged. The sequence generator is a 16-bit shift register with linear feedback, and it advances only when a group completes.

Top module: `ppw_whitener`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wh_vld` and `wh_bit` are both 0.
- R2: `wh_vld` is high for exactly one cycle. That cycle follows the clock edge that accepted the fourth raw bit of a group. Two consecutive cycles never both carry `wh_vld`.
- R3: When `wh_vld` is high, `wh_bit` equals the XOR of the four raw bits of the group, XORed with bit 15 of the sequence register as it stood when the group's last bit was accepted.
- R4: `raw_bit` is ignored in any cycle where `raw_vld` is low. Idle cycles of any length inside or between groups change neither the grouping nor the result.
- R5: The sequence register is 16 bits and is loaded with 16'hACE1 at reset. On each step it shifts left by one. The new bit 0 is bit15 ^ bit14 ^ bit12 ^ bit3, which is the polynomial x^16+x^15+x^13+x^4+1. The register never holds zero.
- R6: The sequence register steps exactly once per emitted output bit and holds its value in every other cycle. Gaps in the input therefore do not shift which sequence bit pairs with which group.
- R7: Between valid pulses, `wh_bit` holds the last emitted value.
- R8: A reset that arrives partway through a group discards the partial group and reloads the seed. The next four accepted bits form a fresh group.
- R9: For N accepted raw bits after reset, exactly floor(N/4) valid pulses are produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_bit | input | 1 | Raw random bit |
| raw_vld | input | 1 | High when raw_bit is to be accepted this cycle |
| wh_bit | output | 1 | Whitened output bit |
| wh_vld | output | 1 | One-cycle strobe marking a new wh_bit |

## Verification
The stream is driven with back-to-back valid bits, with random sparse valid strobes, and with long idle runs in which `raw_bit` toggles while `raw_vld` is low. Together these separate a correct four-bit grouping from designs that count clock cycles instead of accepted bits, or that let ignored bits leak in. Directed groups of all ones and all zeros isolate the sequence term, since their parity is 0, so any wrong tap or wrong output bit of the register shows directly. A reset placed after one, two and three bits of a group shows whether partial parity and the register seed are properly discarded.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    // Group-tracking states of the fold controller
    typedef enum logic [1:0] {
        GRP_FIRST = 2'd0,
        GRP_MID   = 2'd1,
        GRP_LAST  = 2'd2
    } grp_state_e;

    localparam int unsigned SEQ_W_DEF    = 16;
    localparam logic [15:0] SEQ_TAPS_DEF = 16'hD008;  // bits 15,14,12,3
    localparam logic [15:0] SEQ_SEED_DEF = 16'hACE1;
    localparam int unsigned FOLD_DEF     = 4;

endpackage

// File: rtl/ppw_seqgen.sv
module ppw_seqgen #(
    parameter int unsigned    SEQ_W    = 16,
    parameter logic [SEQ_W-1:0] TAP_MASK = 16'hD008,
    parameter logic [SEQ_W-1:0] SEED     = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic seq_bit
);

    logic [SEQ_W-1:0] seq_q;
    logic [SEQ_W:0]   fb_chain;

    assign fb_chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < int'(SEQ_W); i++) begin : g_tap
            assign fb_chain[i+1] = fb_chain[i] ^ (TAP_MASK[i] & seq_q[i]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEED;
        end else if (step) begin
            seq_q <= {seq_q[SEQ_W-2:0], fb_chain[SEQ_W]};
        end
    end

    assign seq_bit = seq_q[SEQ_W-1];

    // R5
    seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q != '0);

    // R6
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(seq_q));

endmodule

// File: rtl/ppw_fold.sv
module ppw_fold
    import ppw_pkg::*;
#(
    parameter int unsigned FOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_vld,
    output logic grp_done,
    output logic grp_par
);

    localparam int unsigned CNT_W = (FOLD > 2) ? $clog2(FOLD) : 1;
    localparam logic [CNT_W-1:0] MID_END = CNT_W'(FOLD - 2);

    grp_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             acc_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRP_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRP_FIRST: begin
                if (in_vld) begin
                    state_d = (FOLD > 2) ? GRP_MID : GRP_LAST;
                end
            end
            GRP_MID: begin
                if (in_vld && cnt_q == MID_END) begin
                    state_d = GRP_LAST;
                end
            end
            GRP_LAST: begin
                if (in_vld) begin
                    state_d = GRP_FIRST;
                end
            end
            default: state_d = GRP_FIRST;
        endcase
    end

    // Accumulator and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            cnt_q <= '0;
        end else if (in_vld) begin
            if (state_q == GRP_LAST) begin
                acc_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                acc_q <= acc_q ^ in_bit;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Group outputs
    always_comb begin
        grp_done = in_vld && (state_q == GRP_LAST);
        grp_par  = acc_q ^ in_bit;
    end

    // R2
    last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRP_LAST) |-> (cnt_q == CNT_W'(FOLD - 1)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(cnt_q) && $stable(acc_q)));

    // R2
    done_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> (state_q == GRP_FIRST && cnt_q == '0));

endmodule

// File: rtl/ppw_whitener.sv
module ppw_whitener
    import ppw_pkg::*;
#(
    parameter int unsigned      FOLD     = FOLD_DEF,
    parameter int unsigned      SEQ_W    = SEQ_W_DEF,
    parameter logic [SEQ_W-1:0] TAP_MASK = SEQ_TAPS_DEF,
    parameter logic [SEQ_W-1:0] SEED     = SEQ_SEED_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_bit,
    input  logic raw_vld,
    output logic wh_bit,
    output logic wh_vld
);

    logic grp_done;
    logic grp_par;
    logic seq_bit;

    ppw_fold #(
        .FOLD (FOLD)
    ) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_bit   (raw_bit),
        .in_vld   (raw_vld),
        .grp_done (grp_done),
        .grp_par  (grp_par)
    );

    ppw_seqgen #(
        .SEQ_W    (SEQ_W),
        .TAP_MASK (TAP_MASK),
        .SEED     (SEED)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (grp_done),
        .seq_bit (seq_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wh_vld <= 1'b0;
            wh_bit <= 1'b0;
        end else begin
            wh_vld <= grp_done;
            if (grp_done) begin
                wh_bit <= grp_par ^ seq_bit;
            end
        end
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wh_vld |=> !wh_vld);

    // R2
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wh_vld |-> $past(raw_vld));

    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wh_vld |-> $stable(wh_bit));

endmodule

// File: tb/ppw_whitener_tb.sv
module ppw_whitener_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_bit = 1'b0;
    logic raw_vld = 1'b0;
    logic wh_bit;
    logic wh_vld;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // expected-state model
    logic [15:0] m_seq;
    logic        m_acc;
    int          m_cnt;
    logic        e_vld;
    logic        e_bit;
    int          n_acc_bits;
    int          n_pulses;

    always #10 clk = ~clk;  // 50 MHz

    ppw_whitener u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_bit (raw_bit),
        .raw_vld (raw_vld),
        .wh_bit  (wh_bit),
        .wh_vld  (wh_vld)
    );

    function automatic logic [15:0] seq_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_seq = 16'hACE1;
        m_acc = 1'b0;
        m_cnt = 0;
        e_vld = 1'b0;
        e_bit = 1'b0;
        n_acc_bits = 0;
        n_pulses = 0;
    endtask

    // One cycle: check outputs of the previous edge, then drive new inputs
    task automatic cycle(input logic v, input logic b);
        @(negedge clk);
        check("R2 valid", wh_vld, e_vld);
        if (e_vld) begin
            check("R3 bit", wh_bit, e_bit);
            n_pulses++;
        end else begin
            check("R7/R4 hold", wh_bit, e_bit);
        end
        raw_vld = v;
        raw_bit = b;
        e_vld = 1'b0;
        if (v) begin
            n_acc_bits++;
            m_acc = m_acc ^ b;
            m_cnt++;
            if (m_cnt == 4) begin
                e_vld = 1'b1;
                e_bit = m_acc ^ m_seq[15];
                m_seq = seq_next(m_seq);
                m_acc = 1'b0;
                m_cnt = 0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        raw_vld = 1'b0;
        raw_bit = 1'b0;
        model_reset();
        @(negedge clk);
        check("R1 reset vld", wh_vld, 1'b0);
        check("R1 reset bit", wh_bit, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic rate_check();
        n_run++;
        if (n_pulses + (e_vld ? 1 : 0) != n_acc_bits / 4) begin
            n_fail++;
            $display("FAIL R9 rate: actual %0d expected %0d", n_pulses + (e_vld ? 1 : 0),
                     n_acc_bits / 4);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = 32'd20240611;
        void'($urandom(seed_v));
        model_reset();
        do_reset();
        // R1: first cycle after reset release
        cycle(1'b0, 1'b0);

        // R3/R5: all-ones and all-zeros groups expose the sequence bits
        for (int g = 0; g < 20; g++) begin
            for (int k = 0; k < 4; k++) cycle(1'b1, g[0]);
        end

        // R4/R6: idle gaps with toggling ignored data
        for (int g = 0; g < 30; g++) begin
            for (int k = 0; k < 4; k++) begin
                cycle(1'b1, 1'($urandom));
                for (int z = 0; z < int'($urandom_range(0, 5)); z++) cycle(1'b0, z[0]);
            end
        end
        rate_check();  // R9

        // R8: reset after one, two and three bits of a group
        for (int p = 1; p <= 3; p++) begin
            for (int k = 0; k < p; k++) cycle(1'b1, 1'b1);
            do_reset();
            cycle(1'b1, 1'b0);
            cycle(1'b1, 1'b0);
            cycle(1'b1, 1'b0);
            cycle(1'b1, 1'b0);
            cycle(1'b0, 1'b1);  // R8: fresh group yields seed bit 15 = 1
            cycle(1'b0, 1'b0);
        end

        // Random mix, R3/R9
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            cycle(($urandom_range(0, 3) != 0), 1'($urandom));
        end
        cycle(1'b0, 1'b0);
        rate_check();  // R9

        // Long back-to-back stream, R2/R6
        for (int i = 0; i < 2000; i++) cycle(1'b1, 1'($urandom));
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule